// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block sits on the device side of a memory-mapped security-module register interface. It decides which of five localities owns that interface at any moment. Each locality sees its own 4 KB window of the address space. A byte-wide ownership register sits at the base of every window. A host writes that register to ask for the interface or to hand it back. A read of the same register tells the host three things: whether the module has finished initialising, whether this locality owns the interface, and whether some other locality is waiting for it.

Requests are held in a queue with one flag per locality. When the interface has no owner, the queue is served at once. When the owner releases, the interface passes in the same clock edge to the highest-numbered waiting locality. Each grant raises a one-cycle change pulse for the interrupt logic next to this block. The index of the current owner is driven out for the command and data paths that sit beside the arbiter.

Top module: `loc_arbiter`

## Requirements
- R1: While `rst` is high, on the clock edges it is sampled, `owner_valid`, `loc_change` and `bus_rdata` are driven to 0 and the request queue is cleared.
- R2: Bit 7 (ready) of the ownership register reads 0 from reset until `init_done` has been seen high on a clock edge. From then on it reads 1, even if `init_done` drops again. Grants do not depend on this bit.
- R3: Address bits [14:12] select the locality window. The ownership register is at window offset 0. A read of locality 5 to 7, or of any non-zero offset, returns 0x00. A write to any of these addresses has no effect.
- R4: A write with bit 1 (request) set queues a request for the writing locality. If the interface has no owner, the request is granted on the clock edge after the write. A read from the owner's window then shows bit 7 and bit 5 (owner) both set.
- R5: A write with bit 5 set gives up ownership if the writing locality is the owner. The same write from any other locality has no effect.
- R6: Bit 2 (waiting) reads 1 only in the owner's window, and only while another locality has a queued request. It reads 0 in every other window.
- R7: On release, the highest-numbered queued locality is granted on the same edge. If nothing is queued, `owner_valid` goes to 0.
- R8: A request write from the current owner, or from a locality that is already queued, changes neither the queue nor the owner.
- R9: `loc_change` is high for exactly one cycle for every grant. It is high in the same cycle that `owner_idx` first shows the new owner.
- R10: A read in any window other than the owner's returns 0 in bit 5.
- R11: Read data is registered. `bus_rdata` holds the register value in the cycle after `bus_rd` is sampled high, and it reflects the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Module initialisation finished |
| bus_addr | input | 15 | Byte address; bits [14:12] select the locality |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_idx | output | 3 | Index of the owning locality |
| loc_change | output | 1 | One-cycle pulse on every grant |

## Verification
The queue is driven with three patterns. The first is a request while the interface has no owner; it separates the one-cycle grant from a same-cycle grant. The second is several requests queued behind an owner and then released one by one; the order in which `owner_idx` changes shows whether priority goes to the highest number or follows arrival order. The third is a set of writes that must be ignored: duplicate requests, a release from a non-owner, and requests to unmapped windows and offsets. Their effect is measured by whether a stale entry turns up in a later grant or in the waiting bit. Reads taken before and after `init_done`, and in owner and non-owner windows, separate the ready, owner and waiting bits from one another.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // Bit positions inside the per-window ownership register.
  localparam int BIT_READY = 7;
  localparam int BIT_OWNER = 5;
  localparam int BIT_WAIT  = 2;
  localparam int BIT_REQ   = 1;

  // Decoded write to an ownership register.
  typedef struct packed {
    logic req;
    logic rel;
  } own_cmd_t;
endpackage

// File: rtl/loc_reg_port.sv
module loc_reg_port
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 15,
  parameter int WIN_LSB = 12,
  parameter int DATA_W  = 8,
  localparam int LOC_W  = ADDR_W - WIN_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_done,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  input  logic               owner_valid,
  input  logic [LOC_W-1:0]   owner_idx,
  input  logic [NUM_LOC-1:0] pending,
  output own_cmd_t           cmd,
  output logic [LOC_W-1:0]   cmd_loc,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               ready
);
  logic [LOC_W-1:0]   win;
  logic               in_map;
  logic               is_own;
  logic               rd_hit;
  logic [DATA_W-1:0]  rd_val;
  logic [NUM_LOC-1:0] self_mask;

  assign win     = bus_addr[ADDR_W-1:WIN_LSB];
  assign in_map  = ({1'b0, win} < (LOC_W+1)'(NUM_LOC)) && (bus_addr[WIN_LSB-1:0] == '0);
  assign cmd_loc = win;
  assign cmd.req = bus_wr && in_map && bus_wdata[BIT_REQ];
  assign cmd.rel = bus_wr && in_map && bus_wdata[BIT_OWNER];

  assign rd_hit    = bus_rd && in_map;
  assign is_own    = owner_valid && (owner_idx == win);
  assign self_mask = NUM_LOC'(1) << win;

  always_comb begin
    rd_val            = '0;
    rd_val[BIT_READY] = ready;
    rd_val[BIT_OWNER] = is_own;
    rd_val[BIT_WAIT]  = is_own && |(pending & ~self_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ready     <= ready | init_done;
      bus_rdata <= rd_hit ? rd_val : '0;
    end
  end

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_unmapped_read_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_map) |=> (bus_rdata == '0));
  assert_other_window_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !(owner_valid && owner_idx == win)) |=> !bus_rdata[BIT_OWNER]);
endmodule

// File: rtl/loc_req_queue.sv
module loc_req_queue #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] set_vec,
  input  logic [NUM_LOC-1:0] clr_vec,
  output logic [NUM_LOC-1:0] pending
);
  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)             pending[g] <= 1'b0;
        else if (clr_vec[g]) pending[g] <= 1'b0;
        else if (set_vec[g]) pending[g] <= 1'b1;
      end
    end
  endgenerate

  assert_grant_dequeues_R8: assert property (@(posedge clk) disable iff (rst)
    (|clr_vec) |=> ((pending & $past(clr_vec)) == '0));
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_vec));
endmodule

// File: rtl/loc_grant_ctl.sv
module loc_grant_ctl #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] pending,
  input  logic               rel_wr,
  input  logic [LOC_W-1:0]   rel_loc,
  output logic [NUM_LOC-1:0] grant_vec,
  output logic               owner_valid,
  output logic [LOC_W-1:0]   owner_idx,
  output logic               loc_change
);
  logic             rel_now;
  logic             free;
  logic             grant;
  logic [LOC_W-1:0] pick;

  assign rel_now = rel_wr && owner_valid && (rel_loc == owner_idx);
  assign free    = !owner_valid || rel_now;
  assign grant   = free && (|pending);

  // Highest-numbered queued locality wins: later iterations override.
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pending[i]) pick = LOC_W'(i);
    end
  end

  assign grant_vec = grant ? (NUM_LOC'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_valid <= 1'b0;
      owner_idx   <= '0;
      loc_change  <= 1'b0;
    end else begin
      loc_change <= grant;
      if (grant) begin
        owner_valid <= 1'b1;
        owner_idx   <= pick;
      end else if (rel_now) begin
        owner_valid <= 1'b0;
      end
    end
  end

  assert_rise_pulses_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(owner_valid) |-> loc_change);
  assert_pulse_has_owner_R9: assert property (@(posedge clk) disable iff (rst)
    loc_change |-> owner_valid);
  assert_owner_range_R7: assert property (@(posedge clk) disable iff (rst)
    owner_valid |-> ({1'b0, owner_idx} < (LOC_W+1)'(NUM_LOC)));
  assert_foreign_release_R5: assert property (@(posedge clk) disable iff (rst)
    (owner_valid && !rel_now && !grant) |=> (owner_valid && $stable(owner_idx)));
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 15,
  parameter int WIN_LSB = 12,
  parameter int DATA_W  = 8,
  localparam int LOC_W  = ADDR_W - WIN_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              owner_valid,
  output logic [LOC_W-1:0]  owner_idx,
  output logic              loc_change
);
  own_cmd_t           cmd;
  logic [LOC_W-1:0]   cmd_loc;
  logic [NUM_LOC-1:0] pending;
  logic [NUM_LOC-1:0] set_vec;
  logic [NUM_LOC-1:0] grant_vec;
  logic               ready;
  logic               from_owner;

  assign from_owner = owner_valid && (owner_idx == cmd_loc);
  assign set_vec    = (cmd.req && !from_owner) ? (NUM_LOC'(1) << cmd_loc) : '0;

  loc_reg_port #(
    .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .DATA_W(DATA_W)
  ) u_port (
    .clk(clk), .rst(rst), .init_done(init_done),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .owner_valid(owner_valid), .owner_idx(owner_idx), .pending(pending),
    .cmd(cmd), .cmd_loc(cmd_loc), .bus_rdata(bus_rdata), .ready(ready)
  );

  loc_req_queue #(.NUM_LOC(NUM_LOC)) u_queue (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(grant_vec), .pending(pending)
  );

  loc_grant_ctl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_grant (
    .clk(clk), .rst(rst), .pending(pending),
    .rel_wr(cmd.rel), .rel_loc(cmd_loc), .grant_vec(grant_vec),
    .owner_valid(owner_valid), .owner_idx(owner_idx), .loc_change(loc_change)
  );

  assert_owner_not_queued_R8: assert property (@(posedge clk) disable iff (rst)
    owner_valid |-> !pending[owner_idx]);
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/sim_loc_arbiter.sv
module sim_loc_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_done = 1'b0;
  logic [14:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        owner_valid;
  logic [2:0]  owner_idx;
  logic        loc_change;

  int total = 0;
  int bad = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  loc_arbiter u0 (
    .clk(clk), .rst(rst), .init_done(init_done), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .owner_valid(owner_valid),
    .owner_idx(owner_idx), .loc_change(loc_change)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the registered read data one cycle after each read.
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) chk("R11 unexpected read data", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(int loc, int off, logic [7:0] d);
    bus_addr  = 15'((loc << 12) | off);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(int loc, int off, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = 15'((loc << 12) | off);
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic owner(int v, int idx, int pulse, string tag);
    chk({tag, " owner_valid"}, owner_valid, v);
    if (v != 0) chk({tag, " owner_idx"}, owner_idx, idx);
    chk({tag, " loc_change"}, loc_change, pulse);
  endtask

  initial begin
    #(20 * 100000);
    chk("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    owner(0, 0, 0, "R1 reset");
    chk("R1 reset rdata", bus_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    rd(0, 0, 8'h00, "R2 ready low after reset");

    // R4: request while the interface is free; grant follows one edge later
    wr(0, 0, 8'h02);
    owner(0, 0, 0, "R4 no same-cycle grant");
    @(negedge clk);
    owner(1, 0, 1, "R4/R9 grant to 0");
    @(negedge clk);
    owner(1, 0, 0, "R9 pulse one cycle");
    rd(0, 0, 8'h20, "R2 owner before init");
    rd(3, 0, 8'h00, "R10 other window");

    init_done = 1'b1;
    @(negedge clk);
    rd(0, 0, 8'hA0, "R4 owner window ready+owner");
    rd(3, 0, 8'h80, "R10 other window after init");
    init_done = 1'b0;
    rd(0, 0, 8'hA0, "R2 ready sticky");

    // R6: queue two requests behind the owner
    wr(1, 0, 8'h02);
    wr(3, 0, 8'h02);
    rd(0, 0, 8'hA4, "R6 waiting shown to owner");
    rd(1, 0, 8'h80, "R6 waiting hidden from queued window");

    // R8: duplicates; R5: foreign release; R3: unmapped writes
    wr(3, 0, 8'h02);
    wr(0, 0, 8'h02);
    wr(1, 0, 8'h20);
    owner(1, 0, 0, "R5 foreign release ignored");
    wr(5, 0, 8'h02);
    wr(2, 'h18, 8'h02);
    wr(6, 0, 8'h20);
    owner(1, 0, 0, "R3 unmapped writes ignored");
    rd(5, 0, 8'h00, "R3 unmapped window read");
    rd(0, 'h04, 8'h00, "R3 non-zero offset read");

    // R7: hand-off on release, highest queued first
    wr(0, 0, 8'h20);
    owner(1, 3, 1, "R7 hand-off to 3");
    @(negedge clk);
    owner(1, 3, 0, "R9 hand-off pulse one cycle");
    rd(0, 0, 8'h80, "R5 old owner lost ownership");
    rd(3, 0, 8'hA4, "R6 new owner sees waiting");
    wr(3, 0, 8'h20);
    owner(1, 1, 1, "R7 hand-off to 1");
    rd(1, 0, 8'hA0, "R8/R3 no stale requests queued");

    // R7: arrival order does not matter
    wr(2, 0, 8'h02);
    wr(4, 0, 8'h02);
    wr(1, 0, 8'h20);
    owner(1, 4, 1, "R7 highest wins over earlier 2");
    wr(4, 0, 8'h20);
    owner(1, 2, 1, "R7 then 2");
    wr(2, 0, 8'h20);
    owner(0, 0, 0, "R7 empty queue leaves no owner");
    @(negedge clk);
    owner(0, 0, 0, "R8 no stale grant later");
    rd(2, 0, 8'h80, "R10 released window");

    @(negedge clk);
    chk("R11 all reads answered", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule